// File: doc/BRIEF.md
# Combined Program Counter and Status Word Register

This block keeps the program counter of a core with a 26-bit address space and the processor status in a single 32-bit register. The status part holds four condition flags in bits [31:28], two interrupt mask bits in bits 27 and 26, and a two-bit privilege mode in bits [1:0]. The word-aligned program counter fills bits [25:2]. Reading the register gives the whole merged word, so software can recover the status by clearing bits [25:2].

A write port loads a new 32-bit value. A status-update flag and the mode currently held in the register decide how much of that value is taken. With the flag clear, only the program counter is taken. With the flag set in user mode (mode 0), the program counter and the condition flags are taken, so a user-mode attempt to raise privilege or change the interrupt masks is dropped. With the flag set in any other mode, the whole word is taken. A separate step strobe advances the program counter by one word for sequential fetch.

The mode field acts as the state of the block. The states are `MODE_USR` (0), `MODE_SYS1` (1), `MODE_SYS2` (2) and `MODE_SVC` (3). A write that takes the whole word moves from any privileged state to the state encoded in bits [1:0] of the written value. `MODE_USR` has no way out except reset. Reset enters `MODE_SVC`. Every update decodes into one of five write scopes:
- `SCOPE_NONE`: hold.
- `SCOPE_STEP`: advance the program counter.
- `SCOPE_PC`: load the program counter.
- `SCOPE_PC_FLAGS`: load the program counter and the flags.
- `SCOPE_ALL`: load the full word.

Top module: `pcsr_reg`

## Requirements
- R1: While reset is active and in the first cycle after it, the read word is 0x0C000003: supervisor mode, both interrupt masks set, flags clear, program counter zero.
- R2: A write with the status-update flag set while the held mode is 3 replaces the entire 32-bit word with the written value.
- R3: A write with the status-update flag set while the held mode is 0 replaces bits [31:28] and [25:2]. Bits [27:26] and [1:0] keep their old values, so writing mode 3 from user mode leaves the mode at 0.
- R4: A write with the status-update flag clear replaces only bits [25:2] and leaves bits [31:26] and [1:0] unchanged, in every mode.
- R5: A step strobe without a write adds 4 to the word's bits [25:0]. The addition wraps from 0x03FFFFFC to 0 and leaves bits [31:26] and [1:0] unchanged.
- R6: When a write and a step strobe occur in the same cycle, only the write takes effect.
- R7: With neither write nor step, the read word holds its value.
- R8: Held modes 1 and 2 have the same write rights as mode 3: a write with the status-update flag set replaces the entire word.
- R9: Every update appears on the read word one clock edge after it is presented, and the read word comes straight from registered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load the register from wr_data |
| wr_data | input | 32 | Value to load, using the merged word layout |
| wr_set_status | input | 1 | Status-update flag for the write |
| step_en | input | 1 | Advance the program counter by one word |
| rd_word | output | 32 | Merged program counter and status word |

## Verification
On every cycle the assertions check these rules: the full-word load in privileged modes, the protection of the masks and mode in user mode, the freezing of all status bits on a plain write, the step arithmetic with its wrap, and the hold when idle. Only the bench scenarios can show the following. A whole sequence of privilege changes ends in user mode and cannot climb back out. The exact values after reset, the wrap at the top of the 26-bit space, and the write-over-step priority come out as required when they are chained the way a program would use them.

// File: rtl/pcsr_pkg.sv
package pcsr_pkg;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 26;
    localparam int FLAG_W   = 4;
    localparam int MASK_W   = 2;
    localparam int MODE_W   = 2;
    localparam int PC_W     = ADDR_W - 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_USR  = 2'd0,
        MODE_SYS1 = 2'd1,
        MODE_SYS2 = 2'd2,
        MODE_SVC  = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        SCOPE_NONE,
        SCOPE_STEP,
        SCOPE_PC,
        SCOPE_PC_FLAGS,
        SCOPE_ALL
    } scope_e;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [MASK_W-1:0] irq_mask;
        logic [PC_W-1:0]   pc;
        mode_e             mode;
    } pcsr_word_t;
endpackage

// File: rtl/pcsr_scope_dec.sv
module pcsr_scope_dec
    import pcsr_pkg::*;
(
    input  logic   wr_en,
    input  logic   wr_set_status,
    input  logic   step_en,
    input  mode_e  cur_mode,
    output scope_e scope
);
    always_comb begin
        scope = SCOPE_NONE;
        if (wr_en) begin
            if (!wr_set_status) begin
                scope = SCOPE_PC;
            end else begin
                unique case (cur_mode)
                    MODE_USR:                      scope = SCOPE_PC_FLAGS;
                    MODE_SYS1, MODE_SYS2, MODE_SVC: scope = SCOPE_ALL;
                endcase
            end
        end else if (step_en) begin
            scope = SCOPE_STEP;
        end
    end
endmodule

// File: rtl/pcsr_pc_field.sv
module pcsr_pc_field
    import pcsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  scope_e          scope,
    input  logic [PC_W-1:0] load_pc,
    output logic [PC_W-1:0] pc_q
);
    logic [PC_W-1:0] pc_d;

    always_comb begin
        pc_d = pc_q;
        unique case (scope)
            SCOPE_NONE:                         pc_d = pc_q;
            SCOPE_STEP:                         pc_d = pc_q + PC_W'(1);
            SCOPE_PC, SCOPE_PC_FLAGS, SCOPE_ALL: pc_d = load_pc;
            default:                            pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end
endmodule

// File: rtl/pcsr_status_field.sv
module pcsr_status_field
    import pcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  scope_e            scope,
    input  logic [FLAG_W-1:0] load_flags,
    input  logic [MASK_W-1:0] load_mask,
    input  mode_e             load_mode,
    output logic [FLAG_W-1:0] flags_q,
    output logic [MASK_W-1:0] mask_q,
    output mode_e             mode_q
);
    logic [FLAG_W-1:0] flags_d;
    logic [MASK_W-1:0] mask_d;
    mode_e             mode_d;

    always_comb begin
        flags_d = flags_q;
        mask_d  = mask_q;
        mode_d  = mode_q;
        unique case (scope)
            SCOPE_NONE, SCOPE_STEP, SCOPE_PC: ;
            SCOPE_PC_FLAGS: flags_d = load_flags;
            SCOPE_ALL: begin
                flags_d = load_flags;
                mask_d  = load_mask;
                mode_d  = load_mode;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            mask_q  <= '1;
            mode_q  <= MODE_SVC;
        end else begin
            flags_q <= flags_d;
            mask_q  <= mask_d;
            mode_q  <= mode_d;
        end
    end
endmodule

// File: rtl/pcsr_reg.sv
module pcsr_reg
    import pcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_set_status,
    input  logic              step_en,
    output logic [WORD_W-1:0] rd_word
);
    pcsr_word_t        wr_fields;
    pcsr_word_t        rd_fields;
    scope_e            scope;
    logic [PC_W-1:0]   pc_q;
    logic [FLAG_W-1:0] flags_q;
    logic [MASK_W-1:0] mask_q;
    mode_e             mode_q;

    assign wr_fields = pcsr_word_t'(wr_data);

    pcsr_scope_dec u_dec (
        .wr_en        (wr_en),
        .wr_set_status(wr_set_status),
        .step_en      (step_en),
        .cur_mode     (mode_q),
        .scope        (scope)
    );

    pcsr_pc_field u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .scope  (scope),
        .load_pc(wr_fields.pc),
        .pc_q   (pc_q)
    );

    pcsr_status_field u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .scope     (scope),
        .load_flags(wr_fields.flags),
        .load_mask (wr_fields.irq_mask),
        .load_mode (wr_fields.mode),
        .flags_q   (flags_q),
        .mask_q    (mask_q),
        .mode_q    (mode_q)
    );

    always_comb begin
        rd_fields.flags    = flags_q;
        rd_fields.irq_mask = mask_q;
        rd_fields.pc       = pc_q;
        rd_fields.mode     = mode_q;
    end

    assign rd_word = WORD_W'(rd_fields);
endmodule

// File: rtl/pcsr_reg_chk.sv
module pcsr_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        wr_set_status,
    input logic        step_en,
    input logic [31:0] rd_word
);
    // R2, R8: privileged status write loads everything
    a_r2_priv_full_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_set_status && rd_word[1:0] != 2'd0) |=> rd_word == $past(wr_data));

    // R3: user mode cannot change masks or mode
    a_r3_user_protects: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_set_status && rd_word[1:0] == 2'd0) |=>
        (rd_word[27:26] == $past(rd_word[27:26]) && rd_word[1:0] == 2'd0 &&
         rd_word[31:28] == $past(wr_data[31:28]) && rd_word[25:2] == $past(wr_data[25:2])));

    // R4: plain write freezes status
    a_r4_plain_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_set_status) |=>
        (rd_word[31:26] == $past(rd_word[31:26]) && rd_word[1:0] == $past(rd_word[1:0]) &&
         rd_word[25:2] == $past(wr_data[25:2])));

    // R5: step adds one word with wrap
    a_r5_step_adds_word: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && step_en) |=>
        (rd_word[25:2] == $past(rd_word[25:2]) + 24'd1 &&
         rd_word[31:26] == $past(rd_word[31:26]) && rd_word[1:0] == $past(rd_word[1:0])));

    // R7: idle hold
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !step_en) |=> $stable(rd_word));
endmodule

bind pcsr_reg pcsr_reg_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .wr_set_status(wr_set_status),
    .step_en      (step_en),
    .rd_word      (rd_word)
);

// File: tb/pcsr_reg_tb_top.sv
module pcsr_reg_tb_top;
    localparam logic [31:0] PCM = 32'h03FF_FFFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_set_status = 1'b0;
    logic        step_en = 1'b0;
    logic [31:0] rd_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] model;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    pcsr_reg dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_set_status(wr_set_status), .step_en(step_en), .rd_word(rd_word)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // monitor: pops one expectation after each edge that follows a driven op
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) check(tag_q.pop_front(), rd_word, exp_q.pop_front());
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 0; step_en = 0; wr_set_status = 0;
        @(negedge clk);
        check("R1 during reset", rd_word, 32'h0C00_0003);
        rst_n = 1'b1;
        model = 32'h0C00_0003;
        @(negedge clk);
        check("R1 after reset", rd_word, 32'h0C00_0003);
    endtask

    // driver: applies one operation and pushes the expected read word
    task automatic drive(input logic we, input logic [31:0] d, input logic st,
                         input logic inc, input string tag);
        @(negedge clk);
        wr_en = we; wr_data = d; wr_set_status = st; step_en = inc;
        if (we) begin
            if (!st)                 model = (model & ~PCM) | (d & PCM);
            else if (model[1:0] == 0) model = {d[31:28], model[27:26], d[25:2], model[1:0]};
            else                     model = d;
        end else if (inc) begin
            model = {model[31:26], model[25:2] + 24'd1, model[1:0]};
        end
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 32'hDEAD_BEEF, 1, 0, "R7 idle hold");
    endtask

    initial begin
        do_reset();
        // privileged full load into user mode with flags and one mask (R2, R9)
        drive(1, 32'hF400_0000 | 32'h0000_1230, 1, 0, "R2 svc full load");
        idle(2);
        // user attempts to enter supervisor and change masks (R3)
        drive(1, 32'h3800_0003 | 32'h0000_4560, 1, 0, "R3 user write protected");
        // plain write in user mode (R4)
        drive(1, 32'hCB00_0002 | 32'h0000_7890, 0, 0, "R4 plain write user");
        drive(0, 32'h0, 0, 1, "R5 step user");
        drive(1, 32'h0000_0000 | PCM, 0, 0, "R4 plain write to top");
        drive(0, 32'h0, 0, 1, "R5 step wrap");
        drive(1, 32'h0000_0100, 1, 1, "R6 write beats step");
        idle(1);
        // back to privileged modes via reset (R8)
        do_reset();
        drive(1, 32'h5000_0001 | 32'h0000_0040, 0, 0, "R4 plain write svc");
        drive(1, 32'h5400_0001 | 32'h0000_0040, 1, 0, "R2 svc to mode1");
        drive(1, 32'hA800_0002 | 32'h0000_0800, 1, 0, "R8 mode1 full load");
        drive(1, 32'h6C00_0003 | 32'h0000_0ABC, 1, 0, "R8 mode2 full load");
        drive(0, 32'h0, 0, 1, "R5 step svc");
        drive(1, 32'h1C00_0000 | 32'h0000_0010, 1, 1, "R6 write beats step svc");
        drive(1, 32'hF000_0003, 1, 0, "R3 user cannot rise");
        idle(2);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule